// File: doc/BRIEF.md
# Flat Page-Table Address Translator

This block turns 32-bit device virtual addresses into physical addresses. The translation data is a single-level table in memory that holds one 32-bit descriptor for each 4 KiB page. The table covers the whole 4 GiB virtual space, so it has 2^20 descriptors. A small fully associative cache of recent translations sits in front of the table. When a lookup misses, a walker issues one memory read for the matching descriptor. A valid descriptor fills the cache and produces a response. An invalid descriptor produces a fault response and fills nothing.

Software sets up the block through a small register port:
- a table base address;
- a two-bit enable field that gates invalidation;
- an invalidate command, which either drops every cached translation or drops only the pages inside an inclusive window given by two bound registers;
- a completion flag, which the block raises when a window invalidation ends and which software clears by writing zero.

While a walk or an invalidation is in progress, the translation port holds `xl_ready` low.

Top module: `flat_xlate_unit`

## Requirements
- R1: After reset, `xl_ready` is 1, `rsp_valid` and `walk_req` are 0, and the table base, enable, bound and completion registers all read 0.
- R2: On a miss, exactly one single-cycle `walk_req` pulse is issued, at address base + vaddr[31:12]*4. A descriptor with bit 1 set gives fault code 0 (none), paddr = {desc[31:12], vaddr[11:0]} and `rsp_nonsec` = desc bit 3.
- R3: A request that hits a cached translation is answered in the cycle after it is accepted, with no memory read.
- R4: A descriptor with bit 1 clear, including an all-zero one, gives fault code 1 (translation fault). It caches nothing, so a repeat of that page walks again, and it does not move the replacement pointer.
- R5: The cache has 8 entries, filled in round-robin order. The ninth distinct page replaces the oldest fill.
- R6: Writing a value with bit 1 set to the command register (offset 0x5C0) drops every cached entry, provided the enable field is nonzero.
- R7: Writing 0x1 to the command register drops only the cached pages whose number lies between start[31:12] (offset 0x5C4) and end[31:12] (offset 0x5C8), both ends included. Pages outside that window stay cached.
- R8: When enable bits 1:0 (offset 0x5D8) are both 0, a command write has no effect: cached entries remain and the completion flag stays 0.
- R9: At the end of a window invalidation, the completion register (offset 0x60C) reads 1. Writing 0 to it clears it. A full invalidation does not set it.
- R10: `xl_ready` is 0 while a walk is outstanding and while an invalidation runs.
- R11: A lookup that matches more than one entry answers with fault code 2 (multi-hit). Because the block never caches the same page twice, a correct run never produces fault code 2.
- R12: The base (offset 0x000), start and end registers read back exactly the 32-bit value written. The enable register reads back its 2 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xl_valid | input | 1 | Translation request present |
| xl_vaddr | input | 32 | Virtual address to translate |
| xl_ready | output | 1 | Request accepted on this edge when high |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_fault | output | 2 | 0 none, 1 translation fault, 2 multi-hit |
| rsp_nonsec | output | 1 | Non-secure bit of the translation |
| walk_req | output | 1 | Descriptor read request (one-cycle pulse) |
| walk_addr | output | 32 | Descriptor byte address |
| walk_rvalid | input | 1 | Descriptor data returned |
| walk_rdata | input | 32 | Descriptor contents |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |

## Verification
The bench first sweeps page numbers in order, so that every request misses. Then it replays the same pages with different offsets, so that every request hits. Comparing the number of walks in these two passes separates hits from misses, and the pages that miss later show exactly which slot round-robin replacement chose. Pages whose descriptors are invalid or zero are placed among valid ones. This shows that a fault caches nothing and does not move the pointer. A window invalidation is run with bounds that carry nonzero low bits. Probing pages at each bound, just outside each bound and far from the window then tells inclusive from exclusive comparison and page-number from byte-address comparison. A final 64-page sweep after a full invalidation checks every descriptor address and translation against values the bench computes arithmetically.

// File: rtl/fxu_pkg.sv
package fxu_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned PAGE_SHIFT = 12;
  localparam int unsigned VPN_W      = ADDR_W - PAGE_SHIFT;
  localparam int unsigned CFG_AW     = 12;

  localparam logic [CFG_AW-1:0] OFS_BASE  = 12'h000;
  localparam logic [CFG_AW-1:0] OFS_CMD   = 12'h5C0;
  localparam logic [CFG_AW-1:0] OFS_LO    = 12'h5C4;
  localparam logic [CFG_AW-1:0] OFS_HI    = 12'h5C8;
  localparam logic [CFG_AW-1:0] OFS_SEL   = 12'h5D8;
  localparam logic [CFG_AW-1:0] OFS_DONE  = 12'h60C;

  localparam int unsigned DESC_VALID_BIT = 1;
  localparam int unsigned DESC_NS_BIT    = 3;
  localparam int unsigned CMD_RANGE_BIT  = 0;
  localparam int unsigned CMD_FULL_BIT   = 1;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_XLATE = 2'd1,
    FLT_MULTI = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_SWEEP = 2'd3
  } ctrl_state_e;
endpackage

// File: rtl/fxu_regs.sv
module fxu_regs
  import fxu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              done_set,
  output logic [ADDR_W-1:0] tbl_base,
  output logic [VPN_W-1:0]  win_lo_vpn,
  output logic [VPN_W-1:0]  win_hi_vpn,
  output logic              cmd_full,
  output logic              cmd_range,
  output logic              done_flag
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic [ADDR_W-1:0] lo_q, lo_d;
  logic [ADDR_W-1:0] hi_q, hi_d;
  logic [1:0]        sel_q, sel_d;
  logic              done_q, done_d;
  logic              cmd_wr;

  always_comb begin
    base_d = base_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    sel_d  = sel_q;
    done_d = done_q;
    if (cfg_we) begin
      unique case (cfg_addr)
        OFS_BASE: base_d = cfg_wdata;
        OFS_LO:   lo_d   = cfg_wdata;
        OFS_HI:   hi_d   = cfg_wdata;
        OFS_SEL:  sel_d  = cfg_wdata[1:0];
        OFS_DONE: if (cfg_wdata == '0) done_d = 1'b0;
        default:  ;
      endcase
    end
    if (done_set) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      sel_q  <= '0;
      done_q <= 1'b0;
    end else begin
      base_q <= base_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      sel_q  <= sel_d;
      done_q <= done_d;
    end
  end

  assign cmd_wr    = cfg_we && (cfg_addr == OFS_CMD) && (sel_q != 2'b00);
  assign cmd_full  = cmd_wr && cfg_wdata[CMD_FULL_BIT];
  assign cmd_range = cmd_wr && !cfg_wdata[CMD_FULL_BIT] && cfg_wdata[CMD_RANGE_BIT];

  always_comb begin
    unique case (cfg_addr)
      OFS_BASE: cfg_rdata = base_q;
      OFS_LO:   cfg_rdata = lo_q;
      OFS_HI:   cfg_rdata = hi_q;
      OFS_SEL:  cfg_rdata = {{(ADDR_W-2){1'b0}}, sel_q};
      OFS_DONE: cfg_rdata = {{(ADDR_W-1){1'b0}}, done_q};
      default:  cfg_rdata = '0;
    endcase
  end

  assign tbl_base   = base_q;
  assign win_lo_vpn = lo_q[ADDR_W-1:PAGE_SHIFT];
  assign win_hi_vpn = hi_q[ADDR_W-1:PAGE_SHIFT];
  assign done_flag  = done_q;
endmodule

// File: rtl/fxu_tlb.sv
module fxu_tlb
  import fxu_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VPN_W-1:0]   look_vpn,
  output logic [ENTRIES-1:0] hit_vec,
  output logic [VPN_W-1:0]   hit_ppn,
  output logic               hit_ns,
  input  logic               fill_en,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [VPN_W-1:0]   fill_ppn,
  input  logic               fill_ns,
  input  logic               flush_all,
  input  logic               sweep_en,
  input  logic [IDX_W-1:0]   sweep_idx,
  input  logic [VPN_W-1:0]   win_lo,
  input  logic [VPN_W-1:0]   win_hi
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] val_q, val_d;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [VPN_W-1:0]   ppn_q [ENTRIES];
  logic               ns_q  [ENTRIES];
  logic [IDX_W-1:0]   rr_q, rr_d;
  logic [VPN_W-1:0]   sw_vpn;
  logic               sw_inwin;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = val_q[g] && (vpn_q[g] == look_vpn);
  end

  always_comb begin
    hit_ppn = '0;
    hit_ns  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        hit_ppn = hit_ppn | ppn_q[i];
        hit_ns  = hit_ns | ns_q[i];
      end
    end
  end

  assign sw_vpn   = vpn_q[sweep_idx];
  assign sw_inwin = (sw_vpn >= win_lo) && (sw_vpn <= win_hi);

  always_comb begin
    val_d = val_q;
    rr_d  = rr_q;
    if (flush_all) begin
      val_d = '0;
    end else if (sweep_en) begin
      if (sw_inwin) val_d[sweep_idx] = 1'b0;
    end else if (fill_en) begin
      val_d[rr_q] = 1'b1;
      rr_d        = (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      rr_q  <= '0;
    end else begin
      val_q <= val_d;
      rr_q  <= rr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush_all && !sweep_en) begin
      vpn_q[rr_q] <= fill_vpn;
      ppn_q[rr_q] <= fill_ppn;
      ns_q[rr_q]  <= fill_ns;
    end
  end
endmodule

// File: rtl/fxu_ctrl.sv
module fxu_ctrl
  import fxu_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xl_valid,
  input  logic [ADDR_W-1:0]  xl_vaddr,
  output logic               xl_ready,
  output logic               rsp_valid,
  output logic [ADDR_W-1:0]  rsp_paddr,
  output logic [1:0]         rsp_fault,
  output logic               rsp_nonsec,
  output logic               walk_req,
  output logic [ADDR_W-1:0]  walk_addr,
  input  logic               walk_rvalid,
  input  logic [ADDR_W-1:0]  walk_rdata,
  input  logic [ADDR_W-1:0]  tbl_base,
  input  logic               cmd_full,
  input  logic               cmd_range,
  output logic               done_set,
  input  logic [ENTRIES-1:0] hit_vec,
  input  logic [VPN_W-1:0]   hit_ppn,
  input  logic               hit_ns,
  output logic               fill_en,
  output logic [VPN_W-1:0]   fill_vpn,
  output logic [VPN_W-1:0]   fill_ppn,
  output logic               fill_ns,
  output logic               flush_all,
  output logic               sweep_en,
  output logic [IDX_W-1:0]   sweep_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  ctrl_state_e       st_q, st_d;
  logic [ADDR_W-1:0] va_q, va_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              pf_q, pf_d, pr_q, pr_d;
  logic              rv_q, rv_d;
  logic [ADDR_W-1:0] pa_q, pa_d;
  logic [1:0]        ft_q, ft_d;
  logic              ns_q, ns_d;
  logic              rsp_en;
  int unsigned       nhit;

  assign xl_ready = (st_q == ST_IDLE) && !pf_q && !pr_q;
  assign nhit     = $countones(hit_vec);

  always_comb begin
    st_d      = st_q;
    va_d      = va_q;
    idx_d     = idx_q;
    pf_d      = pf_q | cmd_full;
    pr_d      = pr_q | cmd_range;
    rv_d      = 1'b0;
    pa_d      = pa_q;
    ft_d      = ft_q;
    ns_d      = ns_q;
    rsp_en    = 1'b0;
    walk_req  = 1'b0;
    fill_en   = 1'b0;
    flush_all = 1'b0;
    sweep_en  = 1'b0;
    done_set  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (pf_q) begin
          flush_all = 1'b1;
          pf_d      = cmd_full;
        end else if (pr_q) begin
          st_d  = ST_SWEEP;
          idx_d = '0;
          pr_d  = cmd_range;
        end else if (xl_valid) begin
          if (nhit > 1) begin
            rsp_en = 1'b1;
            pa_d   = '0;
            ft_d   = FLT_MULTI;
            ns_d   = 1'b0;
          end else if (nhit == 1) begin
            rsp_en = 1'b1;
            pa_d   = {hit_ppn, xl_vaddr[PAGE_SHIFT-1:0]};
            ft_d   = FLT_NONE;
            ns_d   = hit_ns;
          end else begin
            va_d = xl_vaddr;
            st_d = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: begin
        walk_req = 1'b1;
        st_d     = ST_WAIT;
      end
      ST_WAIT: begin
        if (walk_rvalid) begin
          rsp_en = 1'b1;
          st_d   = ST_IDLE;
          if (walk_rdata[DESC_VALID_BIT]) begin
            fill_en = 1'b1;
            pa_d    = {walk_rdata[ADDR_W-1:PAGE_SHIFT], va_q[PAGE_SHIFT-1:0]};
            ft_d    = FLT_NONE;
            ns_d    = walk_rdata[DESC_NS_BIT];
          end else begin
            pa_d = '0;
            ft_d = FLT_XLATE;
            ns_d = 1'b0;
          end
        end
      end
      ST_SWEEP: begin
        sweep_en = 1'b1;
        if (idx_q == LAST) begin
          done_set = 1'b1;
          st_d     = ST_IDLE;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    rv_d = rsp_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      va_q  <= '0;
      idx_q <= '0;
      pf_q  <= 1'b0;
      pr_q  <= 1'b0;
      rv_q  <= 1'b0;
      pa_q  <= '0;
      ft_q  <= '0;
      ns_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      va_q  <= va_d;
      idx_q <= idx_d;
      pf_q  <= pf_d;
      pr_q  <= pr_d;
      rv_q  <= rv_d;
      if (rsp_en) begin
        pa_q <= pa_d;
        ft_q <= ft_d;
        ns_q <= ns_d;
      end
    end
  end

  assign walk_addr  = tbl_base + {{(ADDR_W-VPN_W-2){1'b0}}, va_q[ADDR_W-1:PAGE_SHIFT], 2'b00};
  assign fill_vpn   = va_q[ADDR_W-1:PAGE_SHIFT];
  assign fill_ppn   = walk_rdata[ADDR_W-1:PAGE_SHIFT];
  assign fill_ns    = walk_rdata[DESC_NS_BIT];
  assign sweep_idx  = idx_q;
  assign rsp_valid  = rv_q;
  assign rsp_paddr  = pa_q;
  assign rsp_fault  = ft_q;
  assign rsp_nonsec = ns_q;
endmodule

// File: rtl/flat_xlate_unit.sv
module flat_xlate_unit
  import fxu_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xl_valid,
  input  logic [31:0]       xl_vaddr,
  output logic              xl_ready,
  output logic              rsp_valid,
  output logic [31:0]       rsp_paddr,
  output logic [1:0]        rsp_fault,
  output logic              rsp_nonsec,
  output logic              walk_req,
  output logic [31:0]       walk_addr,
  input  logic              walk_rvalid,
  input  logic [31:0]       walk_rdata,
  input  logic              cfg_we,
  input  logic [11:0]       cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata
);
  logic [ADDR_W-1:0]  tbl_base;
  logic [VPN_W-1:0]   win_lo_vpn, win_hi_vpn;
  logic               cmd_full, cmd_range, done_set, done_flag;
  logic [ENTRIES-1:0] hit_vec;
  logic [VPN_W-1:0]   hit_ppn, fill_vpn, fill_ppn;
  logic               hit_ns, fill_en, fill_ns, flush_all, sweep_en;
  logic [IDX_W-1:0]   sweep_idx;

  fxu_regs i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .done_set   (done_set),
    .tbl_base   (tbl_base),
    .win_lo_vpn (win_lo_vpn),
    .win_hi_vpn (win_hi_vpn),
    .cmd_full   (cmd_full),
    .cmd_range  (cmd_range),
    .done_flag  (done_flag)
  );

  fxu_tlb #(.ENTRIES(ENTRIES)) i_tlb (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_vpn  (xl_vaddr[ADDR_W-1:PAGE_SHIFT]),
    .hit_vec   (hit_vec),
    .hit_ppn   (hit_ppn),
    .hit_ns    (hit_ns),
    .fill_en   (fill_en),
    .fill_vpn  (fill_vpn),
    .fill_ppn  (fill_ppn),
    .fill_ns   (fill_ns),
    .flush_all (flush_all),
    .sweep_en  (sweep_en),
    .sweep_idx (sweep_idx),
    .win_lo    (win_lo_vpn),
    .win_hi    (win_hi_vpn)
  );

  fxu_ctrl #(.ENTRIES(ENTRIES)) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .xl_valid    (xl_valid),
    .xl_vaddr    (xl_vaddr),
    .xl_ready    (xl_ready),
    .rsp_valid   (rsp_valid),
    .rsp_paddr   (rsp_paddr),
    .rsp_fault   (rsp_fault),
    .rsp_nonsec  (rsp_nonsec),
    .walk_req    (walk_req),
    .walk_addr   (walk_addr),
    .walk_rvalid (walk_rvalid),
    .walk_rdata  (walk_rdata),
    .tbl_base    (tbl_base),
    .cmd_full    (cmd_full),
    .cmd_range   (cmd_range),
    .done_set    (done_set),
    .hit_vec     (hit_vec),
    .hit_ppn     (hit_ppn),
    .hit_ns      (hit_ns),
    .fill_en     (fill_en),
    .fill_vpn    (fill_vpn),
    .fill_ppn    (fill_ppn),
    .fill_ns     (fill_ns),
    .flush_all   (flush_all),
    .sweep_en    (sweep_en),
    .sweep_idx   (sweep_idx)
  );
endmodule

// File: rtl/fxu_checker.sv
module fxu_checker #(
  parameter int unsigned ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               xl_ready,
  input logic               walk_req,
  input logic               walk_rvalid,
  input logic [31:0]        walk_rdata,
  input logic [ENTRIES-1:0] hit_vec,
  input logic               fill_en,
  input logic               sweep_en,
  input logic               done_flag
);
  assert_one_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_single_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |=> !walk_req);

  assert_stall_walk_R10: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> !xl_ready);

  assert_stall_sweep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_en |-> !xl_ready);

  assert_fill_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> (walk_rvalid && walk_rdata[1]));

  assert_done_after_sweep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(sweep_en));
endmodule

bind flat_xlate_unit fxu_checker #(.ENTRIES(ENTRIES)) i_fxu_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .xl_ready    (xl_ready),
  .walk_req    (walk_req),
  .walk_rvalid (walk_rvalid),
  .walk_rdata  (walk_rdata),
  .hit_vec     (hit_vec),
  .fill_en     (fill_en),
  .sweep_en    (sweep_en),
  .done_flag   (done_flag)
);

// File: tb/test_flat_xlate_unit.sv
`timescale 1ns/1ps
module test_flat_xlate_unit;
  logic        clk, rst_n;
  logic        xl_valid;
  logic [31:0] xl_vaddr;
  logic        xl_ready, rsp_valid, rsp_nonsec, walk_req;
  logic [31:0] rsp_paddr, walk_addr;
  logic [1:0]  rsp_fault;
  logic        walk_rvalid;
  logic [31:0] walk_rdata;
  logic        cfg_we;
  logic [11:0] cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;

  int tests = 0;
  int fails = 0;
  int walk_cnt = 0;
  logic [31:0] last_walk_addr;
  logic        p1, p2;
  logic [31:0] a1, a2;

  localparam logic [31:0] BASE = 32'h0040_0000;

  flat_xlate_unit i_flat_xlate_unit (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] desc_of(input logic [19:0] vpn);
    logic [19:0] ppn;
    ppn = 20'((vpn * 13) + 20'h3C1);
    if (vpn[3:0] == 4'hF) return 32'h0;
    if (vpn[3:0] == 4'hE) return {ppn, 12'h008};
    return {ppn, (vpn[0] ? 12'h00A : 12'h002)};
  endfunction

  // descriptor memory with two-cycle latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1 <= 1'b0; p2 <= 1'b0; a1 <= '0; a2 <= '0;
      walk_cnt <= 0; last_walk_addr <= '0;
    end else begin
      p1 <= walk_req; a1 <= walk_addr;
      p2 <= p1;       a2 <= a1;
      if (walk_req) begin
        walk_cnt <= walk_cnt + 1;
        last_walk_addr <= walk_addr;
      end
    end
  end
  assign walk_rvalid = p2;
  assign walk_rdata  = p2 ? desc_of(20'((a2 - BASE) >> 2)) : 32'h0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  // exp_walk: 1 miss, 0 hit, -1 either
  task automatic xlate(input logic [31:0] va, input int exp_walk, input string req);
    int w0, lat;
    logic [31:0] d, exp_pa;
    logic [1:0] exp_f;
    d = desc_of(va[31:12]);
    if (d[1]) begin exp_f = 2'd0; exp_pa = {d[31:12], va[11:0]}; end
    else      begin exp_f = 2'd1; exp_pa = 32'h0; end
    @(negedge clk);
    w0 = walk_cnt;
    xl_valid = 1'b1; xl_vaddr = va;
    while (!xl_ready) @(negedge clk);
    @(negedge clk);
    xl_valid = 1'b0;
    lat = 0;
    if (!rsp_valid && exp_walk == 1)
      check(xl_ready == 1'b0, "R10 ready low during walk", 32'(xl_ready), 32'h0);
    while (!rsp_valid && lat < 50) begin @(negedge clk); lat++; end
    check(rsp_fault == exp_f && rsp_fault != 2'd2, {req, " fault code (R11 no multi-hit)"}, 32'(rsp_fault), 32'(exp_f));
    if (exp_f == 2'd0) begin
      check(rsp_paddr == exp_pa, {req, " paddr"}, rsp_paddr, exp_pa);
      check(rsp_nonsec == d[3], {req, " nonsec"}, 32'(rsp_nonsec), 32'(d[3]));
    end
    if (exp_walk >= 0)
      check(walk_cnt - w0 == exp_walk, {req, " walk count"}, 32'(walk_cnt - w0), 32'(exp_walk));
    if (exp_walk == 0)
      check(lat == 0, "R3 hit latency", 32'(lat), 32'h0);
    if (walk_cnt != w0)
      check(last_walk_addr == BASE + {10'h0, va[31:12], 2'b00}, "R2 descriptor address",
            last_walk_addr, BASE + {10'h0, va[31:12], 2'b00});
  endtask

  function automatic logic [31:0] va_of(input int vpn, input int salt);
    return {20'(vpn), 12'((vpn * 12'h123 + salt * 12'h2F1) & 12'hFFF)};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'h1, 32'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    int n;
    xl_valid = 0; xl_vaddr = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check(xl_ready == 1'b1, "R1 ready", 32'(xl_ready), 32'h1);
    check(rsp_valid == 1'b0 && walk_req == 1'b0, "R1 idle outputs", {30'h0, rsp_valid, walk_req}, 32'h0);
    foreach (r[i]) ;
    rd(12'h000, r); check(r == 0, "R1 base", r, 0);
    rd(12'h5D8, r); check(r == 0, "R1 enable", r, 0);
    rd(12'h5C4, r); check(r == 0, "R1 start", r, 0);
    rd(12'h5C8, r); check(r == 0, "R1 end", r, 0);
    rd(12'h60C, r); check(r == 0, "R1 done", r, 0);

    // R12 readback
    wr(12'h000, BASE);
    wr(12'h5D8, 32'hFFFF_FFFF);
    rd(12'h000, r); check(r == BASE, "R12 base", r, BASE);
    rd(12'h5D8, r); check(r == 32'h3, "R12 enable", r, 32'h3);

    // R2 misses over pages 0..7
    for (int v = 0; v < 8; v++) xlate(va_of(v, 0), 1, "R2 miss");
    // R3 hits
    for (int v = 0; v < 8; v++) xlate(va_of(v, 1), 0, "R3 hit");
    // R5 round robin: page 8 replaces slot of page 0
    xlate(va_of(8, 0), 1, "R5 ninth page");
    for (int v = 1; v < 8; v++) xlate(va_of(v, 2), 0, "R5 survivors");
    xlate(va_of(0, 3), 1, "R5 oldest evicted");
    xlate(va_of(1, 3), 1, "R5 next evicted");
    // R4 faults: no fill, pointer unmoved
    xlate(va_of(14, 0), 1, "R4 invalid desc");
    xlate(va_of(14, 1), 1, "R4 invalid desc again");
    xlate(va_of(15, 0), 1, "R4 zero desc");
    xlate(va_of(9, 0), 1, "R4 fill after fault");
    xlate(va_of(4, 0), 0, "R4 pointer unmoved");
    xlate(va_of(3, 0), 1, "R4 slot reused");
    // cache now holds 8,0,1,9,3,5,6,7

    // R7 window invalidate on pages 1..5 with low junk bits
    wr(12'h5C4, 32'h0000_1ABC);
    wr(12'h5C8, 32'h0000_5FFF);
    rd(12'h5C4, r); check(r == 32'h0000_1ABC, "R12 start", r, 32'h0000_1ABC);
    rd(12'h5C8, r); check(r == 32'h0000_5FFF, "R12 end", r, 32'h0000_5FFF);
    wr(12'h5C0, 32'h1);
    n = 0;
    do begin rd(12'h60C, r); n++; end while (r == 0 && n < 40);
    check(r == 32'h1, "R9 done after window", r, 32'h1);
    xlate(va_of(0, 4), 0, "R7 below window kept");
    xlate(va_of(6, 4), 0, "R7 above window kept");
    xlate(va_of(7, 4), 0, "R7 kept");
    xlate(va_of(8, 4), 0, "R7 kept");
    xlate(va_of(9, 4), 0, "R7 kept");
    xlate(va_of(1, 4), 1, "R7 low bound dropped");
    xlate(va_of(3, 4), 1, "R7 inside dropped");
    xlate(va_of(5, 4), 1, "R7 high bound dropped");
    wr(12'h60C, 32'h0);
    rd(12'h60C, r); check(r == 0, "R9 done cleared", r, 0);

    // R8 enable field zero: commands ignored
    wr(12'h5D8, 32'h0);
    wr(12'h5C0, 32'h2);
    wr(12'h5C4, 32'h0);
    wr(12'h5C8, 32'hFFFF_F000);
    wr(12'h5C0, 32'h1);
    repeat (12) @(negedge clk);
    rd(12'h60C, r); check(r == 0, "R8 done stays clear", r, 0);
    xlate(va_of(0, 5), 0, "R8 entry kept");
    xlate(va_of(8, 5), 0, "R8 entry kept");
    xlate(va_of(9, 5), 0, "R8 entry kept");

    // R6 full invalidate with only enable bit 1
    wr(12'h5D8, 32'h2);
    wr(12'h5C0, 32'h2);
    rd(12'h60C, r); check(r == 0, "R9 full leaves done clear", r, 0);
    xlate(va_of(0, 6), 1, "R6 flushed");
    xlate(va_of(8, 6), 1, "R6 flushed");

    // near-exhaustive sweep after another flush
    wr(12'h5C0, 32'h2);
    for (int v = 32; v < 96; v++) xlate(va_of(v, 7), 1, "R2 sweep");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule